// File: doc/BRIEF.md
# I2C Step Sequencer

This block drives the two open-drain lines of an I2C bus from a small step memory instead of a fixed protocol state machine. Software loads the memory one step per write. Each step holds a clock line level, a data line level and a sample flag. It also holds the address of the step that follows, so a transfer is a linked chain of steps. Start conditions, data bits, acknowledge slots and stop conditions are all built as short runs of steps. A data bit takes three steps, with SCL low, then high, then low again. A read bit takes four steps and samples on its third step, while SCL is high.

A write to the control register with the start bit set runs the chain from step 1. The sequencer holds each step for a programmable number of clock cycles, then follows that step's link. A step whose link is 0 ends the chain, and the sequencer falls back to the idle entry, step 0. While the chain runs, the busy flag in the control register reads 1. Bits sampled from SDA shift in at the low end of a 32-bit result register, so the most recent byte read sits in bits 7:0 and up to four bytes can be read back.

Top module: `i2c_step_seq`

## Requirements
- R1: After reset the sequencer is idle. The busy flag (bit 7 when `regSel`=0) reads 0, the result register (`regSel`=3) reads 0, the step divider (`regSel`=2) reads 3, and neither line is pulled low.
- R2: A write with `regSel`=1 stores one step. The step address is in bits 27:18, the sample flag in bit 12, the inverted SCL level in bit 11, the inverted SDA level in bit 10 and the link to the next step in bits 9:0. Bit 13 and all other bits are ignored.
- R3: A write with `regSel`=0 and bit 2 set, made while idle, starts the chain at step 1. The same write with bit 2 clear has no effect.
- R4: When a step ends, the step named by its link runs next. A link of 0 ends the chain and returns the sequencer to idle. The busy flag reads 1 from the step-1 cycle through the last step of the chain.
- R5: During a step, `sclDriveLow` is 1 exactly when the step's SCL level is 0, and `sdaDriveLow` is 1 exactly when its SDA level is 0. While idle, both outputs are 0 whatever step 0 holds.
- R6: Each step lasts divider+1 clock cycles. A write with `regSel`=2 loads the divider from bits 15:0, and a read with `regSel`=2 returns it.
- R7: On the last cycle of a step with the sample flag set, `sdaIn` shifts into bit 0 of the result register, and earlier bits move up by one. Only the newest 32 bits are kept. Steps without the flag leave the result unchanged.
- R8: A start that is accepted clears the result register, so after a chain it holds only that chain's samples.
- R9: A start write that arrives while the chain is running is ignored. The running chain's timing, its line levels and its result are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWr | input | 1 | Register write strobe |
| regSel | input | 2 | Register select: 0 control/status, 1 step load, 2 divider, 3 result |
| regWData | input | 32 | Write data |
| regRData | output | 32 | Read data for the register chosen by `regSel` |
| sdaIn | input | 1 | Sensed level of the SDA line |
| sclDriveLow | output | 1 | Pull SCL low when 1, release it when 0 |
| sdaDriveLow | output | 1 | Pull SDA low when 1, release it when 0 |

## Verification
The hardest case to reach is a start write that lands in the middle of a running chain. It must leave the step timing, the line levels and the partly filled result untouched. The step runner in the bench injects that write at a chosen step while it is comparing every cycle against the programmed levels, so any restart or clearing shows up as a line or result mismatch. Keeping only the newest 32 bits needs a chain longer than the result register. A 36-bit read chain of 145 linked steps reaches it, and a shorter chain run afterwards shows that a new start clears the result.

// File: rtl/i2cseq_pkg.sv
package i2cseq_pkg;

  // register selects on the host port
  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_STEP = 2'd1,
    SEL_DIV  = 2'd2,
    SEL_RES  = 2'd3
  } regSel_e;

  // control and step-load bit positions (fixed by the host software layout)
  localparam int START_BIT   = 2;
  localparam int BUSY_BIT    = 7;
  localparam int ADDR_LSB    = 18;
  localparam int RD_BIT      = 12;
  localparam int SCL_INV_BIT = 11;
  localparam int SDA_INV_BIT = 10;
  localparam int RES_W       = 32;

  // strobes from control to datapath
  typedef struct packed {
    logic loadStep;
    logic loadDiv;
    logic startSeq;
    logic stepDone;
    logic shiftIn;
  } seqStrobe_t;

endpackage

// File: rtl/i2cseq_ctrl.sv
module i2cseq_ctrl
  import i2cseq_pkg::*;
#(
  parameter int STEP_AW = 10,
  parameter int DIV_W   = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWr,
  input  logic [1:0]         regSel,
  input  logic               startBit,
  input  logic [DIV_W-1:0]   divider,
  input  logic [STEP_AW-1:0] curNext,
  input  logic               curRd,
  output logic               running,
  output logic [STEP_AW-1:0] pc,
  output seqStrobe_t         stb
);

  logic [DIV_W-1:0] stepTimer;

  always_comb begin
    stb.loadStep = regWr && (regSel == SEL_STEP);
    stb.loadDiv  = regWr && (regSel == SEL_DIV);
    stb.startSeq = regWr && (regSel == SEL_CTRL) && startBit && !running;
    stb.stepDone = running && (stepTimer == divider);
    stb.shiftIn  = stb.stepDone && curRd;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      running   <= 1'b0;
      pc        <= '0;
      stepTimer <= '0;
    end else if (stb.startSeq) begin
      running   <= 1'b1;
      pc        <= STEP_AW'(1);
      stepTimer <= '0;
    end else if (stb.stepDone) begin
      stepTimer <= '0;
      pc        <= curNext;
      running   <= (curNext != '0);
    end else if (running) begin
      stepTimer <= stepTimer + DIV_W'(1);
    end
  end

endmodule

// File: rtl/i2cseq_dp.sv
module i2cseq_dp
  import i2cseq_pkg::*;
#(
  parameter int STEP_AW = 10,
  parameter int DIV_W   = 16,
  parameter int DEF_DIV = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  seqStrobe_t         stb,
  input  logic [31:0]        regWData,
  input  logic [STEP_AW-1:0] pc,
  input  logic               running,
  input  logic               sdaIn,
  output logic [STEP_AW-1:0] curNext,
  output logic               curRd,
  output logic [DIV_W-1:0]   divider,
  output logic [RES_W-1:0]   result,
  output logic               sclDriveLow,
  output logic               sdaDriveLow
);

  localparam int DEPTH  = 1 << STEP_AW;
  localparam int STEP_W = STEP_AW + 3;

  logic [STEP_W-1:0]  stepMem [DEPTH];
  logic [STEP_W-1:0]  curWord;
  logic [STEP_AW-1:0] wAddr;
  logic               curSclInv;
  logic               curSdaInv;
  logic               unusedIn;

  assign wAddr    = regWData[ADDR_LSB +: STEP_AW];
  assign unusedIn = ^{regWData, stb.stepDone};

  always_ff @(posedge clk) begin
    if (stb.loadStep)
      stepMem[wAddr] <= {regWData[RD_BIT], regWData[SCL_INV_BIT],
                         regWData[SDA_INV_BIT], regWData[STEP_AW-1:0]};
  end

  assign curWord   = stepMem[pc];
  assign curRd     = curWord[STEP_W-1];
  assign curSclInv = curWord[STEP_W-2];
  assign curSdaInv = curWord[STEP_W-3];
  assign curNext   = curWord[STEP_AW-1:0];

  // lines are released whenever no chain runs
  assign sclDriveLow = running && curSclInv;
  assign sdaDriveLow = running && curSdaInv;

  always_ff @(posedge clk) begin
    if (!rstN)
      divider <= DIV_W'(DEF_DIV);
    else if (stb.loadDiv)
      divider <= regWData[DIV_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN || stb.startSeq)
      result <= '0;
    else if (stb.shiftIn)
      result <= {result[RES_W-2:0], sdaIn};
  end

endmodule

// File: rtl/i2c_step_seq.sv
module i2c_step_seq
  import i2cseq_pkg::*;
#(
  parameter int STEP_AW = 10,
  parameter int DIV_W   = 16,
  parameter int DEF_DIV = 3
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWr,
  input  logic [1:0]  regSel,
  input  logic [31:0] regWData,
  output logic [31:0] regRData,
  input  logic        sdaIn,
  output logic        sclDriveLow,
  output logic        sdaDriveLow
);

  seqStrobe_t         stb;
  logic               running;
  logic [STEP_AW-1:0] pc;
  logic [STEP_AW-1:0] curNext;
  logic               curRd;
  logic [DIV_W-1:0]   divider;
  logic [RES_W-1:0]   result;

  i2cseq_ctrl #(.STEP_AW(STEP_AW), .DIV_W(DIV_W)) uCtrl (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regSel(regSel),
    .startBit(regWData[START_BIT]), .divider(divider), .curNext(curNext),
    .curRd(curRd), .running(running), .pc(pc), .stb(stb)
  );

  i2cseq_dp #(.STEP_AW(STEP_AW), .DIV_W(DIV_W), .DEF_DIV(DEF_DIV)) uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .regWData(regWData), .pc(pc),
    .running(running), .sdaIn(sdaIn), .curNext(curNext), .curRd(curRd),
    .divider(divider), .result(result), .sclDriveLow(sclDriveLow),
    .sdaDriveLow(sdaDriveLow)
  );

  always_comb begin
    case (regSel)
      SEL_CTRL: regRData = 32'(running) << BUSY_BIT;
      SEL_DIV:  regRData = 32'(divider);
      SEL_RES:  regRData = result;
      default:  regRData = '0;
    endcase
  end

endmodule

// File: rtl/i2cseq_chk.sv
module i2cseq_chk
  import i2cseq_pkg::*;
#(
  parameter int STEP_AW = 10
) (
  input logic               clk,
  input logic               rstN,
  input logic               regWr,
  input logic [1:0]         regSel,
  input logic               startBit,
  input logic               running,
  input logic [STEP_AW-1:0] pc,
  input seqStrobe_t         stb,
  input logic [RES_W-1:0]   result,
  input logic [STEP_AW-1:0] curNext,
  input logic               sclDriveLow,
  input logic               sdaDriveLow
);

  logic startReq;
  logic unusedStb;
  assign startReq  = regWr && (regSel == SEL_CTRL) && startBit;
  assign unusedStb = ^{stb.loadStep, stb.loadDiv};

  // R5: idle releases both lines
  a_r5_idle_release: assert property (@(posedge clk) disable iff (!rstN)
    !running |-> (!sclDriveLow && !sdaDriveLow));

  // R3: start from idle enters step 1
  a_r3_start_step1: assert property (@(posedge clk) disable iff (!rstN)
    (!running && startReq) |=> (running && pc == STEP_AW'(1)));

  // R6: the step pointer only moves when a step ends
  a_r6_hold_step: assert property (@(posedge clk) disable iff (!rstN)
    (running && !stb.stepDone) |=> $stable(pc));

  // R4: a zero link ends the chain
  a_r4_zero_link_ends: assert property (@(posedge clk) disable iff (!rstN)
    (running && stb.stepDone && curNext == '0) |=> !running);

  // R7: result only moves on a sampling step end or an accepted start
  a_r7_result_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.shiftIn && !stb.startSeq) |=> $stable(result));

  // R9: a start during a chain keeps the chain running
  a_r9_busy_start_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (running && startReq && !stb.stepDone) |=> (running && $stable(pc)));

endmodule

bind i2c_step_seq i2cseq_chk #(.STEP_AW(STEP_AW)) uChk (
  .clk(clk), .rstN(rstN), .regWr(regWr), .regSel(regSel),
  .startBit(regWData[2]), .running(running), .pc(pc), .stb(stb),
  .result(result), .curNext(curNext), .sclDriveLow(sclDriveLow),
  .sdaDriveLow(sdaDriveLow)
);

// File: tb/sim_i2c_step_seq.sv
module sim_i2c_step_seq;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWr = 1'b0;
  logic [1:0]  regSel = 2'd0;
  logic [31:0] regWData = '0;
  logic [31:0] regRData;
  logic        sclDriveLow, sdaDriveLow;
  logic        slaveBit = 1'b1;
  logic        sdaIn;

  int nChecks = 0;
  int nBad = 0;
  int curDiv = 3;

  // program image kept by the bench
  logic pScl [256];
  logic pSda [256];
  logic pRd  [256];
  int   pNext[256];
  int   path [200];
  logic slv  [200];
  int   pathLen;

  assign sdaIn = sdaDriveLow ? 1'b0 : slaveBit;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_step_seq u0 (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regSel(regSel),
    .regWData(regWData), .regRData(regRData), .sdaIn(sdaIn),
    .sclDriveLow(sclDriveLow), .sdaDriveLow(sdaDriveLow)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic writeReg(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    regWr = 1'b1; regSel = sel; regWData = d;
    @(negedge clk);
    regWr = 1'b0; regSel = 2'd0;
  endtask

  task automatic readReg(input logic [1:0] sel, output logic [31:0] v);
    @(negedge clk);
    regSel = sel;
    #1 v = regRData;
    regSel = 2'd0;
  endtask

  task automatic setStep(input int a, input logic scl, input logic sda,
                         input logic rd, input int nxt);
    logic [31:0] d;
    pScl[a] = scl; pSda[a] = sda; pRd[a] = rd; pNext[a] = nxt;
    d = '0;
    d[27:18] = 10'(a);
    d[13] = 1'b1;
    d[12] = rd;
    d[11] = ~scl;
    d[10] = ~sda;
    d[9:0] = 10'(nxt);
    writeReg(2'd1, d);
  endtask

  // runs the chain from step 1, comparing every cycle; pokeAt = path index of a busy start
  task automatic runPath(input int pokeAt, input string tag);
    logic [31:0] expRes;
    logic [31:0] v;
    int st;
    expRes = '0;
    writeReg(2'd0, 32'h4);
    for (int p = 0; p < pathLen; p++) begin
      st = path[p];
      slaveBit = slv[p];
      for (int c = 0; c <= curDiv; c++) begin
        chk({tag, " R5 scl"}, 32'(sclDriveLow), 32'(!pScl[st]));
        chk({tag, " R5 sda"}, 32'(sdaDriveLow), 32'(!pSda[st]));
        chk({tag, " R4 busy"}, 32'(regRData[7]), 32'd1);
        if (p == pokeAt && c == 0) begin
          regWr = 1'b1; regWData = 32'h4; regSel = 2'd0;
        end else begin
          regWr = 1'b0;
        end
        @(negedge clk);
      end
      regWr = 1'b0;
      if (pRd[st]) expRes = {expRes[30:0], slv[p]};
    end
    chk({tag, " R4 idle after chain"}, 32'(regRData[7]), 32'd0);
    chk({tag, " R5 released"}, 32'({sclDriveLow, sdaDriveLow}), 32'd0);
    slaveBit = 1'b1;
    readReg(2'd3, v);
    chk({tag, " R7 result"}, v, expRes);
  endtask

  task automatic buildStartStop();
    setStep(1, 1, 1, 0, 2);
    setStep(2, 1, 0, 0, 3);
    setStep(3, 0, 0, 0, 4);
    setStep(4, 1, 0, 0, 5);
    setStep(5, 1, 1, 0, 0);
    pathLen = 5;
    for (int i = 0; i < 5; i++) begin path[i] = i + 1; slv[i] = 1'b1; end
  endtask

  // nBits read bits at base.., entered from step 1; bit value from pattern
  task automatic buildRead(input int base, input int nBits, input int seed);
    logic b;
    setStep(1, 0, 1, 0, base);
    path[0] = 1; slv[0] = 1'b0;
    for (int i = 0; i < nBits; i++) begin
      int a;
      a = base + 4 * i;
      setStep(a,     0, 1, 0, a + 1);
      setStep(a + 1, 1, 1, 0, a + 2);
      setStep(a + 2, 1, 1, 1, a + 3);
      setStep(a + 3, 0, 1, 0, (i == nBits - 1) ? 0 : a + 4);
      b = 1'(((i * 7 + seed) % 5) < 2);
      for (int k = 0; k < 4; k++) begin
        path[1 + 4 * i + k] = a + k;
        slv[1 + 4 * i + k] = (k == 2) ? b : ~b;
      end
    end
    pathLen = 1 + 4 * nBits;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    readReg(2'd0, v); chk("R1 busy", v, 32'd0);
    readReg(2'd3, v); chk("R1 result", v, 32'd0);
    readReg(2'd2, v); chk("R1 divider", v, 32'd3);
    chk("R1 lines", 32'({sclDriveLow, sdaDriveLow}), 32'd0);
  endtask

  task automatic t_noStartBit();
    logic [31:0] v;
    buildStartStop();
    setStep(0, 0, 0, 0, 0);  // idle entry with low levels must not reach the lines
    writeReg(2'd0, 32'hFFFF_FFFB);
    readReg(2'd0, v); chk("R3 bit2 clear no start", v, 32'd0);
    chk("R5 idle ignores step 0", 32'({sclDriveLow, sdaDriveLow}), 32'd0);
  endtask

  task automatic t_startStop();
    runPath(-1, "R2 start/stop chain");
  endtask

  task automatic t_linked();
    setStep(1, 0, 1, 0, 9);
    setStep(9, 1, 0, 0, 4);
    setStep(4, 0, 0, 0, 0);
    setStep(2, 1, 1, 0, 0);
    setStep(3, 1, 1, 0, 0);
    pathLen = 3;
    path[0] = 1; path[1] = 9; path[2] = 4;
    for (int i = 0; i < 3; i++) slv[i] = 1'b1;
    runPath(-1, "R4 linked order");
  endtask

  task automatic t_divider();
    logic [31:0] v;
    buildStartStop();
    writeReg(2'd2, 32'h0); curDiv = 0;
    readReg(2'd2, v); chk("R6 divider readback 0", v, 32'd0);
    runPath(-1, "R6 div0");
    writeReg(2'd2, 32'hABCD_0005); curDiv = 5;
    readReg(2'd2, v); chk("R6 divider readback 5", v, 32'd5);
    runPath(-1, "R6 div5");
    writeReg(2'd2, 32'h1); curDiv = 1;
  endtask

  task automatic t_readLong();
    buildRead(100, 36, 3);
    runPath(-1, "R7 36-bit read");
  endtask

  task automatic t_readClear();
    buildRead(10, 10, 1);
    runPath(-1, "R8 cleared by start");
  endtask

  task automatic t_busyIgnore();
    buildRead(10, 10, 4);
    runPath(13, "R9 busy start during read");
    buildStartStop();
    runPath(2, "R9 busy start during stop");
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nBad++;
    $display("FAIL watchdog expired (R1..R9 incomplete)");
    $display("  test done: total=%0d bad=%0d", nChecks, nBad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_noStartBit();
    t_startStop();
    t_linked();
    t_divider();
    t_readLong();
    t_readClear();
    t_busyIgnore();
    $display("  test done: total=%0d bad=%0d", nChecks, nBad);
    $finish;
  end

endmodule